// File: doc/BRIEF.md
# Double-Buffered Segmented DAC Input Front-End

This block is the digital side of a parallel-load, current-steering converter. A data word arrives on a parallel bus, 16 bits wide by default and usable down to 14. It first goes into a staging register controlled by an active-low write strobe. It then moves into an output register controlled by an active-high load strobe. Both registers behave as level-sensitive stores. Each one passes its input straight through while its enable is active and holds its value otherwise. Because the two enables have opposite polarity, the pair can run fully transparent (write low, load high). If the two strobes are wired together, the pair forms a master-slave register that updates on the strobe's rising edge. Several converters can share one load strobe and update together.

The output register drives the converter switches in two parts. Its three top bits become seven equally weighted thermometer segment enables. The remaining bits pass unchanged to a binary ladder bus worth one eighth of full scale. A clear input overrides both registers at once, and the power-on reset does the same. A parameter selects whether the clear value is zero scale or midscale. Each rising edge of load, passed through a two-flop synchronizer, produces a single-clock deglitch trigger. This trigger is blocked while clear is active.

Top module: `dbuf_dac_front`

## Requirements
- R1: While `wr_n` is 0 the staging register takes `bus_d`. While `wr_n` is 1 it keeps the last value it took.
- R2: While `ld` is 1, `dac_word` equals the staging register contents, in the same cycle. While `ld` is 0, `dac_word` keeps its value.
- R3: With `wr_n` = 0 and `ld` = 1, `dac_word` equals `bus_d` in the same cycle, with no clock edge needed.
- R4: With `wr_n` and `ld` driven by one signal, a 0-to-1 change presents the bus word that was sampled at the last clock edge while the signal was 0. Bus changes while the signal stays 1 have no effect.
- R5: While `clr` is 1, `dac_word` equals the clear value immediately. After `clr` returns to 0, with `wr_n` = 1 and `ld` = 1, `dac_word` still equals the clear value, which shows that the staging register was cleared too.
- R6: With `CLR_MID` = 0 the clear value is all zeros. With `CLR_MID` = 1 the clear value has only bit `DATA_W-1` set.
- R7: While `rst` is 1, and after it is released with no write, `dac_word` equals the clear value.
- R8: With N equal to `dac_word[DATA_W-1:DATA_W-3]`, `seg_en[i]` is 1 exactly when i < N. For example, N = 0 gives no enables and N = 7 gives all seven.
- R9: `ladder` equals `dac_word[DATA_W-4:0]`.
- R10: Suppose `ld` is raised between clock edges after having been 0 for at least three edges. Then `dg_pulse` is 1 for exactly one cycle, in the interval that follows the second rising edge after the change. At all other times it is 0.
- R11: `dg_pulse` is 0 whenever `clr` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for state holding and the deglitch synchronizer |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_n | input | 1 | Active-low staging register write enable |
| ld | input | 1 | Active-high output register load enable |
| clr | input | 1 | Clear, forces both registers to the clear value |
| bus_d | input | DATA_W | Parallel data word |
| dac_word | output | DATA_W | Output register contents |
| seg_en | output | 7 | Thermometer segment enables |
| ladder | output | DATA_W-3 | Binary ladder bits |
| dg_pulse | output | 1 | One-clock deglitch trigger |

## Verification
The properties assume that `wr_n`, `ld` and `clr` change only between clock edges. They also assume that a load rising edge follows at least a few cycles of `ld` low, so that the synchronizer sees one clean transition per load. The bench drives every input on the falling edge and samples one nanosecond later. It holds `ld` low for three edges before each deglitch trial. With these conditions, the level-sensitive paths and the synchronized pulse can each be predicted from the bench's own model of the registers.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
    localparam int SEG_BITS = 3;
    localparam int SEG_N    = (1 << SEG_BITS) - 1;

    typedef logic [SEG_N-1:0] seg_t;

    typedef struct packed {
        logic wr_n;
        logic ld;
        logic clr;
    } ctl_t;

    function automatic seg_t thermo(input logic [SEG_BITS-1:0] code);
        seg_t s;
        for (int i = 0; i < SEG_N; i++) begin
            s[i] = (code > SEG_BITS'(i));
        end
        return s;
    endfunction
endpackage

// File: rtl/dbuf_hold_stage.sv
module dbuf_hold_stage #(
    parameter int W      = 16,
    parameter bit EN_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         force_clr,
    input  logic [W-1:0] clr_val,
    input  logic         en_pin,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic         en;
    logic [W-1:0] held;

    generate
        if (EN_LOW) begin : g_low
            assign en = ~en_pin;
        end else begin : g_high
            assign en = en_pin;
        end
    endgenerate

    always_comb begin
        if (force_clr)  q = clr_val;
        else if (en)    q = d;
        else            q = held;
    end

    always_ff @(posedge clk) begin
        if (rst) held <= clr_val;
        else     held <= q;
    end

    // R1 / R2: a closed stage keeps its contents across an edge
    assert_stage_hold_R1_R2: assert property (@(posedge clk) disable iff (rst)
        (!en && !force_clr) |=> (en || force_clr || $stable(q)));
endmodule

// File: rtl/dbuf_deglitch_trig.sv
module dbuf_deglitch_trig (
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  logic clr,
    output logic pulse
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= ld;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign pulse = s2 & ~s3 & ~clr;

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
    assert_pulse_origin_R10: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(ld, 2));
    assert_pulse_blocked_R11: assert property (@(posedge clk) disable iff (rst)
        clr |-> !pulse);
endmodule

// File: rtl/dbuf_seg_split.sv
module dbuf_seg_split
    import dbuf_pkg::*;
#(
    parameter int W = 16,
    localparam int LW = W - SEG_BITS
) (
    input  logic [W-1:0]  word,
    output seg_t          seg,
    output logic [LW-1:0] lad
);
    assign seg = thermo(word[W-1 -: SEG_BITS]);
    assign lad = word[LW-1:0];
endmodule

// File: rtl/dbuf_dac_front.sv
module dbuf_dac_front
    import dbuf_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter bit CLR_MID = 1'b0,
    localparam int LAD_W  = DATA_W - SEG_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              ld,
    input  logic              clr,
    input  logic [DATA_W-1:0] bus_d,
    output logic [DATA_W-1:0] dac_word,
    output logic [SEG_N-1:0]  seg_en,
    output logic [LAD_W-1:0]  ladder,
    output logic              dg_pulse
);
    localparam logic [DATA_W-1:0] CLR_VAL =
        CLR_MID ? (DATA_W'(1) << (DATA_W - 1)) : '0;

    ctl_t        ctl;
    logic        force_clr;
    logic [DATA_W-1:0] stage_q;

    assign ctl       = '{wr_n: wr_n, ld: ld, clr: clr};
    assign force_clr = ctl.clr | rst;

    dbuf_hold_stage #(.W(DATA_W), .EN_LOW(1'b1)) u_stage (
        .clk(clk), .rst(rst), .force_clr(force_clr), .clr_val(CLR_VAL),
        .en_pin(ctl.wr_n), .d(bus_d), .q(stage_q)
    );

    dbuf_hold_stage #(.W(DATA_W), .EN_LOW(1'b0)) u_out (
        .clk(clk), .rst(rst), .force_clr(force_clr), .clr_val(CLR_VAL),
        .en_pin(ctl.ld), .d(stage_q), .q(dac_word)
    );

    dbuf_seg_split #(.W(DATA_W)) u_split (
        .word(dac_word), .seg(seg_en), .lad(ladder)
    );

    dbuf_deglitch_trig u_dg (
        .clk(clk), .rst(rst), .ld(ctl.ld), .clr(ctl.clr), .pulse(dg_pulse)
    );

    assert_clear_value_R5_R6: assert property (@(posedge clk) disable iff (rst)
        clr |-> dac_word == CLR_VAL);
    assert_seg_count_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(seg_en) == int'(dac_word[DATA_W-1 -: SEG_BITS]));
    assert_seg_contig_R8: assert property (@(posedge clk) disable iff (rst)
        ((seg_en & (seg_en + 1'b1)) == '0));
    assert_flow_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && ld && !clr) |-> dac_word == bus_d);
endmodule

// File: tb/tb_dbuf_dac_front.sv
module tb_dbuf_dac_front;
    typedef struct packed {
        logic        wr_n;
        logic        ld;
        logic [15:0] bus;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 16'hFFFF, 16'hFFFF},
        '{1'b0, 1'b1, 16'h8000, 16'h8000},
        '{1'b1, 1'b0, 16'h1234, 16'h8000},
        '{1'b0, 1'b0, 16'h1234, 16'h8000},
        '{1'b1, 1'b0, 16'h5555, 16'h8000},
        '{1'b1, 1'b1, 16'h5555, 16'h1234},
        '{1'b1, 1'b0, 16'hAAAA, 16'h1234},
        '{1'b0, 1'b0, 16'h7FFF, 16'h1234},
        '{1'b1, 1'b1, 16'h0000, 16'h7FFF},
        '{1'b1, 1'b1, 16'h0001, 16'h7FFF}
    };

    logic clk = 1'b0;
    logic rst, wr_n, ld, clr;
    logic [15:0] bus_d;
    logic [15:0] dac_word, dac_mid;
    logic [6:0]  seg_en, seg_mid;
    logic [12:0] ladder, lad_mid;
    logic        dg_pulse, dg_mid;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    dbuf_dac_front #(.DATA_W(16), .CLR_MID(1'b0)) dut (
        .clk(clk), .rst(rst), .wr_n(wr_n), .ld(ld), .clr(clr), .bus_d(bus_d),
        .dac_word(dac_word), .seg_en(seg_en), .ladder(ladder), .dg_pulse(dg_pulse)
    );

    dbuf_dac_front #(.DATA_W(16), .CLR_MID(1'b1)) dut_mid (
        .clk(clk), .rst(rst), .wr_n(wr_n), .ld(ld), .clr(clr), .bus_d(bus_d),
        .dac_word(dac_mid), .seg_en(seg_mid), .ladder(lad_mid), .dg_pulse(dg_mid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_seg(input logic [15:0] w);
        return 7'((8'd1 << w[15:13]) - 8'd1);
    endfunction

    task automatic drive(input logic w, input logic l, input logic c, input logic [15:0] b);
        @(negedge clk);
        wr_n = w; ld = l; clr = c; bus_d = b;
        #1;
    endtask

    initial begin
        #(200000 * 8);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_n = 1'b1; ld = 1'b0; clr = 1'b0; bus_d = 16'h3C3C;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        check("R7 reset zero variant", 32'(dac_word), 32'h0000);
        check("R7 R6 reset midscale variant", 32'(dac_mid), 32'h8000);
        check("R8 midscale segments", 32'(seg_mid), 32'h0F);
        check("R9 midscale ladder", 32'(lad_mid), 32'h0);
        check("R10 no pulse in reset", 32'(dg_pulse), 32'h0);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R7 after reset release", 32'(dac_word), 32'h0000);

        // vector table: R1 R2 R3 R4 with R8 R9 decode on every step
        for (int k = 0; k < NV; k++) begin
            drive(VECS[k].wr_n, VECS[k].ld, 1'b0, VECS[k].bus);
            check($sformatf("R1 R2 R3 R4 vec %0d word", k), 32'(dac_word), 32'(VECS[k].exp));
            check($sformatf("R8 vec %0d segments", k), 32'(seg_en), 32'(exp_seg(VECS[k].exp)));
            check($sformatf("R9 vec %0d ladder", k), 32'(ladder), 32'(VECS[k].exp[12:0]));
        end

        // R1: staging keeps contents while wr_n high, observed through ld high
        drive(1'b0, 1'b0, 1'b0, 16'h2468);
        drive(1'b1, 1'b0, 1'b0, 16'h9999);
        drive(1'b1, 1'b1, 1'b0, 16'h1111);
        check("R1 staging holds while write high", 32'(dac_word), 32'h2468);

        // R5 R6: clear, immediate and persistent
        drive(1'b1, 1'b1, 1'b1, 16'hFFFF);
        check("R5 R6 clear zero variant", 32'(dac_word), 32'h0000);
        check("R5 R6 clear midscale variant", 32'(dac_mid), 32'h8000);
        check("R11 no pulse during clear", 32'(dg_pulse), 32'h0);
        drive(1'b1, 1'b1, 1'b0, 16'hFFFF);
        check("R5 staging also cleared", 32'(dac_word), 32'h0000);
        check("R5 staging also cleared midscale", 32'(dac_mid), 32'h8000);

        // R10: one pulse after the second edge following ld rise
        drive(1'b1, 1'b0, 1'b0, 16'h0);
        repeat (3) drive(1'b1, 1'b0, 1'b0, 16'h0);
        drive(1'b1, 1'b1, 1'b0, 16'h0);
        check("R10 sample 0", 32'(dg_pulse), 32'h0);
        drive(1'b1, 1'b1, 1'b0, 16'h0);
        check("R10 sample 1", 32'(dg_pulse), 32'h0);
        drive(1'b1, 1'b1, 1'b0, 16'h0);
        check("R10 sample 2", 32'(dg_pulse), 32'h1);
        drive(1'b1, 1'b1, 1'b0, 16'h0);
        check("R10 sample 3", 32'(dg_pulse), 32'h0);

        // R11: same rise under clear gives no pulse
        repeat (4) drive(1'b1, 1'b0, 1'b0, 16'h0);
        for (int k = 0; k < 4; k++) begin
            drive(1'b1, 1'b1, 1'b1, 16'h0);
            check($sformatf("R11 sample %0d", k), 32'(dg_pulse), 32'h0);
        end
        drive(1'b1, 1'b1, 1'b0, 16'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule